// File: doc/BRIEF.md
# Non-Maskable Interrupt Arbitration Controller

This block decides which of two non-maskable requests is handed to a CPU core, and when. One request comes from an external pin. The pin is passed through a synchroniser and then an edge detector whose active edge is chosen by a 2-bit configuration input. The other request comes from a watchdog pulse, and it counts only while the watchdog's NMI-mode bit is 0. The global interrupt-disable state of the core has no effect on either request.

While a pin handler is running, the block holds new requests and releases them after the core's return strobe. There is one exception to this. A watchdog request arrives while the core has cleared its NMI-in-progress flag. In that case the watchdog is delivered at once and the pin handler is abandoned. A watchdog handler cannot be returned from. Delivering one raises a sticky reset-required flag and freezes the arbiter until system reset.

The controller is a three-state machine:

- `ST_IDLE`: no handler is active.
- `ST_PIN_SVC`: a pin handler is active.
- `ST_WDT_SVC`: a watchdog handler is active. This state is terminal.

Transitions:

- *take-pin*: `ST_IDLE` to `ST_PIN_SVC`, when a pin request is new or pending and no watchdog request is present.
- *take-wdt*: `ST_IDLE` to `ST_WDT_SVC`, when a watchdog request is new or pending.
- *preempt*: `ST_PIN_SVC` to `ST_WDT_SVC`, when a watchdog request arrives with the in-progress flag clear.
- *return*: `ST_PIN_SVC` to `ST_IDLE`, on the return strobe.

`ST_WDT_SVC` has no exit except reset.

Top module: `nmi_arbiter`

## Requirements
- R1: After reset, `ack_o`, `ack_src_o`, `save_ctx_o` and `reset_req_o` are all 0.
- R2: `edge_sel_i` selects the pin edge:
  - 00: pin ignored.
  - 01: rising edge.
  - 10: falling edge.
  - 11: either edge.
  
  A qualifying pin change applied before clock edge k produces an acknowledge visible after edge k+2.
- R3: A `wdt_req_i` pulse with `wdt_rst_mode_i`=1 has no effect. With `wdt_rst_mode_i`=0, a pulse sampled at edge k is acknowledged after edge k, given the controller is idle.
- R4: When a pin request and a watchdog request are present in the same cycle, the watchdog is delivered and the pin request is discarded. It is never delivered later.
- R5: A pin request that arrives during a pin handler is held, whatever `cpu_nmi_busy_i` is. It is delivered after the edge that follows the edge sampling `reti_i`.
- R6: A watchdog request that arrives during a pin handler with `cpu_nmi_busy_i`=1 is held. It is delivered after the edge that follows the edge sampling `reti_i`.
- R7: A watchdog request that arrives during a pin handler with `cpu_nmi_busy_i`=0 is acknowledged after the same edge, with no return needed.
- R8: Each acknowledge is a single cycle with `save_ctx_o` high in the same cycle. `ack_src_o` is 0 for the pin and 1 for the watchdog, and it is 0 whenever `ack_o` is 0.
- R9: A watchdog acknowledge sets `reset_req_o`, which stays 1 until reset. After that, no further acknowledge occurs, and return strobes, pin edges and watchdog pulses are ignored.
- R10: A return strobe while idle changes nothing. A later pin request is still acknowledged normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level_i | input | 1 | Raw asynchronous NMI pin level |
| edge_sel_i | input | 2 | Pin edge mode (00 off, 01 rise, 10 fall, 11 both) |
| wdt_req_i | input | 1 | Watchdog request pulse |
| wdt_rst_mode_i | input | 1 | 1 = watchdog not in NMI mode (request ignored) |
| cpu_nmi_busy_i | input | 1 | Core's NMI-in-progress flag |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | One-cycle acknowledge / vector pulse |
| ack_src_o | output | 1 | Source of the acknowledge (0 pin, 1 watchdog) |
| save_ctx_o | output | 1 | Save PC/status strobe, with every acknowledge |
| reset_req_o | output | 1 | Sticky flag: watchdog serviced, reset required |

## Verification
Each kind of wrong internal state shows up at the ports in a different way and at a different time:

- **Pending flag lost:** the acknowledge that should follow the return strobe by one cycle is missing.
- **Pending flag set when it should not be:** an acknowledge appears after a return that had nothing held.
- **State stuck in `ST_PIN_SVC`:** later pin edges are never acknowledged, even after a return.
- **State that fails to freeze in `ST_WDT_SVC`:** an acknowledge appears after `reset_req_o` is already high.

Every one of these shows within two cycles of the stimulus that should expose it. The edge detector is the exception: a wrong synchroniser depth moves the pin acknowledge off its third edge.

// File: rtl/nmi_arb_pkg.sv
package nmi_arb_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_PIN_SVC  = 2'b01,
        ST_WDT_SVC  = 2'b10
    } svc_state_e;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_WDT = 1'b1
    } nmi_src_e;

endpackage

// File: rtl/nmi_pin_edge.sv
module nmi_pin_edge
    import nmi_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    output logic       evt_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;
    logic         rise, fall;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[TOP-1:0], pin_i};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[TOP];
    end

    assign rise = sync_q[TOP] & ~last_q;
    assign fall = ~sync_q[TOP] & last_q;

    always_comb begin
        unique case (edge_sel_e'(mode_i))
            EDGE_OFF:  evt_o = 1'b0;
            EDGE_RISE: evt_o = rise;
            EDGE_FALL: evt_o = fall;
            EDGE_BOTH: evt_o = rise | fall;
            default:   evt_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/nmi_wdt_qual.sv
module nmi_wdt_qual (
    input  logic req_i,
    input  logic rst_mode_i,
    output logic evt_o
);
    // A watchdog pulse is a non-maskable request only in NMI mode (bit = 0).
    assign evt_o = req_i & ~rst_mode_i;
endmodule

// File: rtl/nmi_svc_fsm.sv
module nmi_svc_fsm
    import nmi_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_evt_i,
    input  logic wdt_evt_i,
    input  logic busy_i,
    input  logic reti_i,
    output logic ack_o,
    output logic src_o,
    output logic save_o,
    output logic reset_req_o
);
    svc_state_e state_q, state_d;
    logic       pin_pend_q, pin_pend_d;
    logic       wdt_pend_q, wdt_pend_d;
    logic       take;
    nmi_src_e   take_src;

    // Next-state and delivery decision
    always_comb begin
        state_d    = state_q;
        pin_pend_d = pin_pend_q;
        wdt_pend_d = wdt_pend_q;
        take       = 1'b0;
        take_src   = SRC_PIN;
        unique case (state_q)
            ST_IDLE: begin
                if (wdt_evt_i || wdt_pend_q) begin          // take-wdt
                    take       = 1'b1;
                    take_src   = SRC_WDT;
                    state_d    = ST_WDT_SVC;
                    pin_pend_d = 1'b0;
                    wdt_pend_d = 1'b0;
                end else if (pin_evt_i || pin_pend_q) begin // take-pin
                    take       = 1'b1;
                    take_src   = SRC_PIN;
                    state_d    = ST_PIN_SVC;
                    pin_pend_d = 1'b0;
                end
            end
            ST_PIN_SVC: begin
                if (wdt_evt_i && !busy_i) begin             // preempt
                    take       = 1'b1;
                    take_src   = SRC_WDT;
                    state_d    = ST_WDT_SVC;
                    pin_pend_d = 1'b0;
                    wdt_pend_d = 1'b0;
                end else begin
                    if (wdt_evt_i)      wdt_pend_d = 1'b1;  // pin dropped if same cycle
                    else if (pin_evt_i) pin_pend_d = 1'b1;
                    if (reti_i)         state_d    = ST_IDLE; // return
                end
            end
            ST_WDT_SVC: begin
                state_d = ST_WDT_SVC;                       // terminal until reset
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pin_pend_q <= 1'b0;
            wdt_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            pin_pend_q <= pin_pend_d;
            wdt_pend_q <= wdt_pend_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o       <= 1'b0;
            src_o       <= 1'b0;
            save_o      <= 1'b0;
            reset_req_o <= 1'b0;
        end else begin
            ack_o       <= take;
            src_o       <= take & (take_src == SRC_WDT);
            save_o      <= take;
            reset_req_o <= reset_req_o | (take & (take_src == SRC_WDT));
        end
    end

    assert_rr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> reset_req_o);

    assert_no_ack_after_wdt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !ack_o);

    assert_rr_rises_with_wdt_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req_o) |-> (ack_o && src_o));

    assert_pin_ack_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !src_o) |-> ($past(state_q) == ST_IDLE));

    assert_preempt_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && src_o && ($past(state_q) == ST_PIN_SVC)) |-> !$past(busy_i));

endmodule

// File: rtl/nmi_arbiter.sv
module nmi_arbiter
    import nmi_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_level_i,
    input  logic [1:0] edge_sel_i,
    input  logic       wdt_req_i,
    input  logic       wdt_rst_mode_i,
    input  logic       cpu_nmi_busy_i,
    input  logic       reti_i,
    output logic       ack_o,
    output logic       ack_src_o,
    output logic       save_ctx_o,
    output logic       reset_req_o
);
    logic pin_evt;
    logic wdt_evt;

    nmi_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_level_i),
        .mode_i (edge_sel_i),
        .evt_o  (pin_evt)
    );

    nmi_wdt_qual u_wdt_qual (
        .req_i      (wdt_req_i),
        .rst_mode_i (wdt_rst_mode_i),
        .evt_o      (wdt_evt)
    );

    nmi_svc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_evt_i   (pin_evt),
        .wdt_evt_i   (wdt_evt),
        .busy_i      (cpu_nmi_busy_i),
        .reti_i      (reti_i),
        .ack_o       (ack_o),
        .src_o       (ack_src_o),
        .save_o      (save_ctx_o),
        .reset_req_o (reset_req_o)
    );

endmodule

// File: tb/nmi_arbiter_tb.sv
`timescale 1ns/1ps
module nmi_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin;
    logic [1:0] mode;
    logic       wdt, wmode, busy, reti;
    logic       ack, src, save, rr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    nmi_arbiter u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_level_i    (pin),
        .edge_sel_i     (mode),
        .wdt_req_i      (wdt),
        .wdt_rst_mode_i (wmode),
        .cpu_nmi_busy_i (busy),
        .reti_i         (reti),
        .ack_o          (ack),
        .ack_src_o      (src),
        .save_ctx_o     (save),
        .reset_req_o    (rr)
    );

    // {pin, mode[1:0], wdt, wmode, busy, reti, exp_ack, exp_src, exp_save, exp_rr}
    localparam int NV = 33;
    localparam logic [10:0] VEC [NV] = '{
        11'b0_01_0000_0000, // 0
        11'b1_01_0000_0000, // 1  rising edge applied
        11'b1_01_0000_0000,
        11'b1_01_0010_1010, // 3  R2 pin ack on third edge
        11'b1_01_0010_0000,
        11'b0_01_0010_0000, // 5  falling, ignored in rise mode
        11'b1_01_0010_0000, // 6  new rise during handler
        11'b1_01_0010_0000,
        11'b1_01_0010_0000, // 8  R5 held
        11'b1_01_0011_0000, // 9  return
        11'b1_01_0000_1010, // 10 R5 delivered after return
        11'b1_01_0000_0000,
        11'b1_01_0001_0000, // 12 return
        11'b0_10_0000_0000, // 13 fall mode, falling edge
        11'b0_10_0000_0000,
        11'b0_10_0010_1010, // 15 R2 fall ack
        11'b0_10_0011_0000, // 16 return
        11'b1_00_0000_0000, // 17 off mode rise
        11'b1_00_0000_0000,
        11'b1_00_0000_0000, // 19 R2 off: nothing
        11'b0_00_0001_0000, // 20 R10 return while idle
        11'b0_00_0000_0000,
        11'b0_00_0000_0000,
        11'b0_11_0000_0000, // 23 both mode
        11'b1_11_0000_0000,
        11'b1_11_0000_0000,
        11'b1_11_0010_1010, // 26 R10 still acked, R2 both
        11'b0_11_0010_0000, // 27 falling edge
        11'b0_11_1100_0000, // 28 R3 wdt in reset mode ignored
        11'b0_11_0010_0000, // 29 R5 held
        11'b0_11_0011_0000, // 30 return
        11'b0_11_0000_1010, // 31 delivered
        11'b0_11_1100_0000  // 32 R3 ignored, busy clear
    };

    task automatic chk(input string req, input logic ea, input logic es,
                       input logic ev, input logic er);
        n_chk++;
        if ({ack, src, save, rr} !== {ea, es, ev, er}) begin
            n_fail++;
            $display("FAIL %s: ack/src/save/rr actual %b%b%b%b expected %b%b%b%b",
                     req, ack, src, save, rr, ea, es, ev, er);
        end
    endtask

    task automatic drive(input logic p, input logic [1:0] m, input logic w,
                         input logic wm, input logic b, input logic r);
        pin = p; mode = m; wdt = w; wmode = wm; busy = b; reti = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pin = 0; mode = 2'b01; wdt = 0; wmode = 0; busy = 0; reti = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    initial begin
        do_reset();
        chk("R1 reset", 0, 0, 0, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][10], VEC[i][9:8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
            chk($sformatf("R2/R5/R8 vector %0d", i),
                VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R3 and R9: watchdog from idle, then everything frozen
        do_reset();
        drive(0, 2'b01, 1, 1, 0, 0);
        chk("R3 ignored in reset mode", 0, 0, 0, 0);
        drive(0, 2'b01, 1, 0, 0, 0);
        chk("R3 wdt ack", 1, 1, 1, 1);
        drive(0, 2'b01, 0, 0, 0, 1);
        chk("R9 sticky, return ignored", 0, 0, 0, 1);
        drive(1, 2'b01, 0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 0, 0);
        drive(1, 2'b01, 1, 0, 0, 0);
        chk("R9 no ack after wdt", 0, 0, 0, 1);
        drive(1, 2'b01, 0, 0, 0, 0);
        chk("R9 still set", 0, 0, 0, 1);

        // R4: simultaneous pin and watchdog
        do_reset();
        drive(1, 2'b01, 0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 0, 0);
        drive(1, 2'b01, 1, 0, 0, 0);
        chk("R4 wdt wins", 1, 1, 1, 1);
        drive(1, 2'b01, 0, 0, 0, 0);
        chk("R4 pin discarded", 0, 0, 0, 1);

        // R7: preemption with in-progress flag clear
        do_reset();
        drive(1, 2'b01, 0, 0, 1, 0);
        drive(1, 2'b01, 0, 0, 1, 0);
        drive(1, 2'b01, 0, 0, 1, 0);
        chk("R7 pin ack first", 1, 0, 1, 0);
        drive(1, 2'b01, 1, 0, 0, 0);
        chk("R7 wdt preempts", 1, 1, 1, 1);

        // R6: watchdog held while flag set
        do_reset();
        drive(1, 2'b01, 0, 0, 1, 0);
        drive(1, 2'b01, 0, 0, 1, 0);
        drive(1, 2'b01, 0, 0, 1, 0);
        chk("R6 pin ack first", 1, 0, 1, 0);
        drive(1, 2'b01, 1, 0, 1, 0);
        chk("R6 wdt held", 0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 1, 0);
        chk("R6 still held", 0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 1, 1);
        chk("R6 return cycle", 0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 0, 0);
        chk("R6 delivered after return", 1, 1, 1, 1);
        drive(1, 2'b01, 0, 0, 0, 0);
        chk("R8 single-cycle pulse", 0, 0, 0, 1);

        finish_run();
    end

endmodule